// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block connects a simple clocked request port to an external static RAM that has no clock. The RAM has 2^AW words of DW bits, one undivided address, a single bidirectional data bus, and two active-low controls: a write strobe and an output enable. The controller turns each accepted request into a fixed sequence of clock cycles on the RAM pins. The number of cycles in each phase is a parameter. The controller drives the data lines only while a write is in progress. For a read it leaves the bus to the RAM and captures the word once the access window has closed. Completion is reported with a one-cycle `done` pulse; on a read, `rd_data` carries the captured word.

A host waits for `ready`, then presents the address, the write data and the direction together with `req_valid`. The request is taken on that clock edge and `ready` stays low until the access ends. Every timing window is a whole number of clock cycles, at least one each. The setup window is the number of cycles the write strobe stays low with the data already driven. The hold window is the number of cycles the data stays driven after the strobe rises. The access window is the number of cycles the output enable stays low before capture.

Top module: `sram_port_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `ready`=1, `done`=0, `mem_we_n`=1, `mem_oe_n`=1, `rd_data`=0, and the controller does not drive `mem_dq`.
- R2: A request is taken only on a rising clock edge where `ready` and `req_valid` are both 1. `req_write`=1 selects a write and 0 selects a read. `ready` is 0 from the next cycle until the done cycle. `req_valid` has no effect while `ready` is 0.
- R3: `mem_we_n` and `mem_oe_n` are never 0 in the same cycle.
- R4: Number the cycles after the accepting edge t=1,2,... For a write, `mem_dq` carries the write data from t=1 to t=SETUP_CYC+HOLD_CYC+1. `mem_we_n` is 0 exactly for t=2 to t=SETUP_CYC+1. `done` is 1 at t=SETUP_CYC+HOLD_CYC+2.
- R5: For a read, the controller releases `mem_dq` and keeps `mem_oe_n`=1 at t=1. `mem_oe_n` is 0 for t=2 to t=ACCESS_CYC+1. The bus is sampled on the edge that ends t=ACCESS_CYC+1, and `done`=1 with that word on `rd_data` at t=ACCESS_CYC+2.
- R6: `mem_addr` equals the accepted request address during every cycle in which `ready` is 0, including address 0 and address 2^AW-1.
- R7: `done` lasts exactly one cycle and coincides with `ready` returning to 1. A new request can be taken on the edge that ends the done cycle.
- R8: `rd_data` keeps the last word read until the next read completes. Writes do not change it.
- R9: The controller drives `mem_dq` only during write phases and never while `mem_oe_n` is 0. After a write the bus stays released, so a following read returns the RAM's word undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address of the request |
| req_wdata | input | DW | Data for a write |
| ready | output | 1 | Controller idle, can take a request |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Last word read |
| mem_addr | output | AW | RAM address lines |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq | inout | DW | Shared RAM data bus |

## Verification
The assertions take the request inputs to be known values at every clock edge. They also take the external RAM to drive the data lines only while output enable is low; any other drive would make the bus-ownership properties meaningless. The bench's RAM model drives the bus only in that case, and it puts complemented junk on the bus until the access window has elapsed. An early capture therefore shows up as wrong data. Requests change only on falling edges. Some tests hold `req_valid` high through a whole busy period so that the model can confirm the extra assertion is ignored.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_WR_ADDR,
    SEQ_WR_STROBE,
    SEQ_WR_HOLD,
    SEQ_RD_TURN,
    SEQ_RD_ACCESS
  } seq_state_t;

  function automatic int unsigned max_of3(input int unsigned a,
                                          input int unsigned b,
                                          input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] remain;

  // Loading N makes 'last' true in the N-th cycle of the phase
  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val - ONE;
    end else if (remain != '0) begin
      remain <= remain - ONE;
    end
  end

  assign last = (remain == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int SETUP_CYC  = 2,
  parameter int HOLD_CYC   = 1,
  parameter int ACCESS_CYC = 3,
  parameter int CW         = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          timer_last,
  output logic          timer_load,
  output logic [CW-1:0] timer_val,
  output logic          latch_req,
  output logic          capture,
  output logic          ready,
  output logic          done,
  output logic          we_n,
  output logic          oe_n,
  output logic          bus_drive
);
  localparam logic [CW-1:0] SETUP_V  = CW'(SETUP_CYC);
  localparam logic [CW-1:0] HOLD_V   = CW'(HOLD_CYC);
  localparam logic [CW-1:0] ACCESS_V = CW'(ACCESS_CYC);

  seq_state_t state, state_n;
  logic       done_n;

  always_comb begin
    state_n    = state;
    timer_load = 1'b0;
    timer_val  = '0;
    latch_req  = 1'b0;
    capture    = 1'b0;
    done_n     = 1'b0;
    unique case (state)
      SEQ_IDLE: begin
        if (req_valid) begin
          latch_req = 1'b1;
          state_n   = req_write ? SEQ_WR_ADDR : SEQ_RD_TURN;
        end
      end
      SEQ_WR_ADDR: begin
        timer_load = 1'b1;
        timer_val  = SETUP_V;
        state_n    = SEQ_WR_STROBE;
      end
      SEQ_WR_STROBE: begin
        if (timer_last) begin
          timer_load = 1'b1;
          timer_val  = HOLD_V;
          state_n    = SEQ_WR_HOLD;
        end
      end
      SEQ_WR_HOLD: begin
        if (timer_last) begin
          done_n  = 1'b1;
          state_n = SEQ_IDLE;
        end
      end
      SEQ_RD_TURN: begin
        timer_load = 1'b1;
        timer_val  = ACCESS_V;
        state_n    = SEQ_RD_ACCESS;
      end
      SEQ_RD_ACCESS: begin
        if (timer_last) begin
          capture = 1'b1;
          done_n  = 1'b1;
          state_n = SEQ_IDLE;
        end
      end
      default: state_n = SEQ_IDLE;
    endcase
  end

  // Pin controls are registered from the next state: no decode glitches
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SEQ_IDLE;
      ready     <= 1'b1;
      done      <= 1'b0;
      we_n      <= 1'b1;
      oe_n      <= 1'b1;
      bus_drive <= 1'b0;
    end else begin
      state     <= state_n;
      ready     <= (state_n == SEQ_IDLE);
      done      <= done_n;
      we_n      <= (state_n != SEQ_WR_STROBE);
      oe_n      <= (state_n != SEQ_RD_ACCESS);
      bus_drive <= (state_n == SEQ_WR_ADDR) || (state_n == SEQ_WR_STROBE) ||
                   (state_n == SEQ_WR_HOLD);
    end
  end
endmodule

// File: rtl/sram_io_path.sv
module sram_io_path #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          latch_req,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          capture,
  input  logic [DW-1:0] bus_in,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] bus_out,
  output logic [DW-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      bus_out  <= '0;
      rd_data  <= '0;
    end else begin
      if (latch_req) begin
        mem_addr <= req_addr;
        bus_out  <= req_wdata;
      end
      if (capture) begin
        rd_data <= bus_in;
      end
    end
  end
endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW         = 8,
  parameter int DW         = 16,
  parameter int SETUP_CYC  = 2,
  parameter int HOLD_CYC   = 1,
  parameter int ACCESS_CYC = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ready,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  inout  wire  [DW-1:0] mem_dq
);
  localparam int MAX_CYC = int'(max_of3(SETUP_CYC, HOLD_CYC, ACCESS_CYC));
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic          timer_load, timer_last, latch_req, capture, bus_drive;
  logic [CW-1:0] timer_val;
  logic [DW-1:0] bus_out;

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .load(timer_load), .load_val(timer_val),
    .last(timer_last)
  );

  sram_seq_fsm #(
    .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC), .ACCESS_CYC(ACCESS_CYC),
    .CW(CW)
  ) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .timer_last(timer_last), .timer_load(timer_load), .timer_val(timer_val),
    .latch_req(latch_req), .capture(capture), .ready(ready), .done(done),
    .we_n(mem_we_n), .oe_n(mem_oe_n), .bus_drive(bus_drive)
  );

  sram_io_path #(.AW(AW), .DW(DW)) u_io (
    .clk(clk), .rst(rst), .latch_req(latch_req), .req_addr(req_addr),
    .req_wdata(req_wdata), .capture(capture), .bus_in(mem_dq),
    .mem_addr(mem_addr), .bus_out(bus_out), .rd_data(rd_data)
  );

  assign mem_dq = bus_drive ? bus_out : {DW{1'bz}};
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          ready,
  input logic          done,
  input logic          we_n,
  input logic          oe_n,
  input logic          drv_en,
  input logic [AW-1:0] mem_addr
);
  assert_enables_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    !(!we_n && !oe_n));

  assert_no_drive_in_read_R9: assert property (@(posedge clk) disable iff (rst)
    drv_en |-> oe_n);

  assert_turnaround_gap_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(oe_n) |-> (!drv_en && !$past(drv_en)));

  assert_accept_drops_ready_R2: assert property (@(posedge clk) disable iff (rst)
    (ready && req_valid) |=> !ready);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_with_ready_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> ready);

  assert_addr_steady_R6: assert property (@(posedge clk) disable iff (rst)
    (!ready && $past(!ready)) |-> $stable(mem_addr));

  assert_data_before_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(we_n) |-> (drv_en && $past(drv_en)));

  assert_data_after_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> drv_en);
endmodule

bind sram_port_ctrl sram_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .ready(ready), .done(done),
  .we_n(mem_we_n), .oe_n(mem_oe_n), .drv_en(bus_drive), .mem_addr(mem_addr)
);

// File: tb/sim_sram_port_ctrl.sv
module sim_sram_port_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int SETUP = 2;
  localparam int HOLD = 1;
  localparam int ACCESS = 3;
  localparam int DEPTH = 1 << AW;
  localparam int WR_END = SETUP + HOLD + 2;
  localparam int RD_END = ACCESS + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic ready, done, mem_we_n, mem_oe_n;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] mem_addr;
  wire  [DW-1:0] mem_dq;

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_port_ctrl #(.AW(AW), .DW(DW), .SETUP_CYC(SETUP), .HOLD_CYC(HOLD),
                   .ACCESS_CYC(ACCESS)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .done(done),
    .rd_data(rd_data), .mem_addr(mem_addr), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq(mem_dq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] init_word(input int a);
    return DW'((a * 37) ^ 16'h5A00);
  endfunction

  // ---------------- behavioural RAM model ----------------
  logic [DW-1:0] ram_mem [DEPTH];
  int            oe_cnt;
  int            lo_cnt;
  logic          prev_we;
  logic [DW-1:0] wcap;
  logic [DW-1:0] ram_q;

  assign ram_q  = (oe_cnt >= ACCESS - 1) ? ram_mem[mem_addr] : ~ram_mem[mem_addr];
  assign mem_dq = (!mem_oe_n) ? ram_q : {DW{1'bz}};

  initial begin
    for (int i = 0; i < DEPTH; i++) ram_mem[i] = init_word(i);
  end

  always @(posedge clk) begin
    if (rst) begin
      oe_cnt  <= 0;
      lo_cnt  <= 0;
      prev_we <= 1'b1;
    end else begin
      chk(!(!mem_we_n && !mem_oe_n), "R3 both enables low", {mem_we_n, mem_oe_n}, 2'b11);
      oe_cnt <= mem_oe_n ? 0 : oe_cnt + 1;
      if (!mem_we_n) begin
        if (lo_cnt == 0) wcap <= mem_dq;
        else chk(mem_dq === wcap, "R4 data stable under strobe", int'(mem_dq), int'(wcap));
        lo_cnt <= lo_cnt + 1;
      end else if (!prev_we) begin
        chk(lo_cnt == SETUP, "R4 strobe width", lo_cnt, SETUP);
        chk(mem_dq === wcap, "R4 data held after strobe", int'(mem_dq), int'(wcap));
        ram_mem[mem_addr] <= wcap;
        lo_cnt <= 0;
      end
      prev_we <= mem_we_n;
    end
  end

  // ---------------- cycle reference model ----------------
  logic [DW-1:0] shadow [DEPTH];
  bit            ref_active;
  int            ref_t;
  bit            ref_wr;
  int            ref_end;
  logic [AW-1:0] ref_addr;
  logic [DW-1:0] ref_wdata;
  logic [DW-1:0] ref_rword;
  logic [DW-1:0] exp_rd;
  bit            started = 1'b0;

  initial begin
    for (int i = 0; i < DEPTH; i++) shadow[i] = init_word(i);
  end

  always @(posedge clk) begin
    if (rst) begin
      ref_active = 1'b0;
      ref_t      = 0;
      exp_rd     = '0;
    end else if (ref_active && ref_t < ref_end) begin
      ref_t = ref_t + 1;
      if (ref_t == ref_end && !ref_wr) exp_rd = ref_rword;
    end else if (req_valid) begin
      ref_active = 1'b1;
      ref_t      = 1;
      ref_wr     = req_write;
      ref_end    = req_write ? WR_END : RD_END;
      ref_addr   = req_addr;
      ref_wdata  = req_wdata;
      ref_rword  = shadow[req_addr];
      if (req_write) shadow[req_addr] = req_wdata;
    end else begin
      ref_active = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (!rst && started) begin
      bit busy, dcyc, we_low, oe_low, drv;
      busy   = ref_active && ref_t < ref_end;
      dcyc   = ref_active && ref_t == ref_end;
      we_low = busy && ref_wr && ref_t >= 2 && ref_t <= SETUP + 1;
      oe_low = busy && !ref_wr && ref_t >= 2 && ref_t <= ACCESS + 1;
      drv    = busy && ref_wr && ref_t >= 1 && ref_t <= SETUP + HOLD + 1;
      chk(ready === !busy, "R2 ready", ready, !busy);
      chk(done === dcyc, "R7 done", done, dcyc);
      chk(mem_we_n === !we_low, "R4 we_n", mem_we_n, !we_low);
      chk(mem_oe_n === !oe_low, "R5 oe_n", mem_oe_n, !oe_low);
      if (busy) chk(mem_addr === ref_addr, "R6 address", mem_addr, ref_addr);
      if (drv) chk(mem_dq === ref_wdata, "R4 write data on bus", int'(mem_dq), int'(ref_wdata));
      chk(rd_data === exp_rd, dcyc && !ref_wr ? "R5 read data" : "R8 rd_data held",
          int'(rd_data), int'(exp_rd));
    end
  end

  // ---------------- stimulus ----------------
  task automatic do_req(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    while (ready !== 1'b1) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (ready !== 1'b1) @(negedge clk);
  endtask

  // Two requests with req_valid held high throughout (R2, R7)
  task automatic pair_req(input bit w0, input logic [AW-1:0] a0, input logic [DW-1:0] d0,
                          input bit w1, input logic [AW-1:0] a1, input logic [DW-1:0] d1);
    @(negedge clk);
    while (ready !== 1'b1) @(negedge clk);
    req_valid = 1'b1; req_write = w0; req_addr = a0; req_wdata = d0;
    @(negedge clk);
    req_write = w1; req_addr = a1; req_wdata = d1;
    while (ready !== 1'b1) @(negedge clk);
    @(negedge clk);
    chk(ready === 1'b0, "R7 accept at end of done cycle", ready, 0);
    req_valid = 1'b0;
    while (ready !== 1'b1) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=%0d expected<=50000 cycles", cyc);
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: values during reset
    chk(ready === 1'b1 && done === 1'b0, "R1 ready/done in reset", {ready, done}, 2'b10);
    chk(mem_we_n === 1'b1 && mem_oe_n === 1'b1, "R1 strobes in reset", {mem_we_n, mem_oe_n}, 2'b11);
    rst = 1'b0;
    @(negedge clk);
    chk(rd_data === '0, "R1 rd_data after reset", int'(rd_data), 0);
    chk(ready === 1'b1 && mem_we_n === 1'b1 && mem_oe_n === 1'b1,
        "R1 idle after reset", {ready, mem_we_n, mem_oe_n}, 3'b111);
    started = 1'b1;

    do_req(1'b1, 8'h00, 16'h1234);            // R4, R6 lowest address
    do_req(1'b1, 8'hFF, 16'hABCD);            // R6 highest address
    do_req(1'b0, 8'hFF, 16'h0000);            // R5, R9
    chk(rd_data === 16'hABCD, "R9 read after write", int'(rd_data), 16'hABCD);
    do_req(1'b0, 8'h00, 16'h0000);
    chk(rd_data === 16'h1234, "R5 read address 0", int'(rd_data), 16'h1234);
    do_req(1'b0, 8'h42, 16'h0000);            // unwritten word
    chk(rd_data === init_word(8'h42), "R5 read unwritten", int'(rd_data), int'(init_word(8'h42)));
    do_req(1'b1, 8'h10, 16'h5555);            // R8: write must not touch rd_data
    chk(rd_data === init_word(8'h42), "R8 rd_data after write", int'(rd_data), int'(init_word(8'h42)));
    pair_req(1'b1, 8'h20, 16'hBEEF, 1'b0, 8'h20, 16'h0000);
    chk(rd_data === 16'hBEEF, "R2 held-valid write then read", int'(rd_data), 16'hBEEF);
    pair_req(1'b0, 8'h10, 16'h0000, 1'b0, 8'h11, 16'h0000);
    chk(rd_data === init_word(8'h11), "R7 back-to-back reads", int'(rd_data), int'(init_word(8'h11)));
    for (int k = 0; k < 12; k++) do_req(1'b1, AW'(k * 19 + 3), DW'(k * 16'h0F0F + 7));
    for (int k = 11; k >= 0; k--) begin
      do_req(1'b0, AW'(k * 19 + 3), '0);
      chk(rd_data === DW'(k * 16'h0F0F + 7), "R5 pattern readback", int'(rd_data),
          int'(DW'(k * 16'h0F0F + 7)));
    end
    repeat (5) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule